// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall time as a plain count of seconds. It runs entirely on a slow oscillator clock and has a simple 32-bit register bus. A prescaler counts oscillator cycles up to a programmable limit and then issues a one-second tick. Each tick advances a 32-bit seconds counter and raises a tick flag. A compare against a programmable alarm value raises an alarm flag. Each flag has its own interrupt enable, and the two enabled flags together drive a single interrupt line.

Every register write is protected in two ways. First, an unlock key must be written to the key register, and one accepted write uses the key up. Second, each accepted write holds the write-ready status low for a fixed number of cycles while it commits. Writes that arrive while the block is locked or busy are dropped. The two flags can only be cleared by writing 0 to them, so a read-modify-write of the control register that writes 1 back never loses a pending event. Software that wants to unlock and then write one register writes the key, polls write-ready, and writes the register.

Top module: `rtc_core`

## Requirements
- R1: After reset the control register reads 0x80 (write-ready set, everything else 0). The seconds, alarm, scratch and key registers read 0. The tick-length register reads its reset parameter. The interrupt output is 0.
- R2: A write to any register other than the key register (offset 0x3C) is dropped unless the key is open. Writing 0xA55A in the low 16 bits of the key register opens the key, which reads as bit 31. Any other key value leaves the key state unchanged.
- R3: One accepted register write closes the key again.
- R4: After an accepted write, write-ready (control bit 7) reads 0 for exactly 3 cycles and then reads 1. A write made while write-ready is 0 is dropped and does not close the key.
- R5: With run set (control bit 0) and tick-length value N (offset 0x0C), the seconds counter (offset 0x04) increases by exactly 1 every N+1 cycles.
- R6: The seconds counter holds its value while run is 0. It wraps from 0xFFFFFFFF to 0.
- R7: Each tick sets the tick flag (control bit 6). Writing 0 to bit 6 clears the flag, and writing 1 to it leaves the flag unchanged.
- R8: The alarm flag (control bit 4) is set one cycle after the seconds counter first equals the alarm register (offset 0x08) while alarm enable (bit 2) is 1. It is never set while alarm enable is 0. It clears only when 0 is written to bit 4.
- R9: The interrupt output equals (tick flag AND tick interrupt enable, bit 5) OR (alarm flag AND alarm interrupt enable, bit 3).
- R10: A write to the seconds register restarts the prescaler, so the next increment comes N+1 cycles after the write.
- R11: The scratch register (offset 0x34) stores any 32-bit value written to it through the gated write path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A prescaler that is off by one shows up within one second period. The seconds readback then moves a cycle early or late, and the bench samples every boundary of that period for several tick lengths. A wrong state in the key or busy logic shows up on the next write: a register either changes when it should not, or fails to change when it should, and the bench reads the register back right after the attempt. A flag that is sticky or clear in the wrong way shows up at once in control bits 6 and 4 and on irq_o, so the bench checks both right after each control write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   // Register offsets (byte addresses decoded by the bus).
   localparam int OFF_CTRL  = 'h00;
   localparam int OFF_SECS  = 'h04;
   localparam int OFF_ALARM = 'h08;
   localparam int OFF_TLEN  = 'h0C;
   localparam int OFF_SCR   = 'h34;
   localparam int OFF_KEY   = 'h3C;

   // Control register bit positions.
   localparam int B_RDY    = 7;
   localparam int B_TICKF  = 6;
   localparam int B_TICKIE = 5;
   localparam int B_ALMF   = 4;
   localparam int B_ALMIE  = 3;
   localparam int B_ALMEN  = 2;
   localparam int B_RUN    = 0;

   localparam int B_KEYOPEN = 31;
   localparam logic [15:0] UNLOCK_CODE = 16'hA55A;

   typedef struct packed {
      logic tick_ie;
      logic alm_ie;
      logic alm_en;
      logic run;
   } rtc_cfg_t;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
   parameter bit          KEY_EN   = 1'b1,
   parameter int          BUSY_CYC = 3,
   parameter int          KEY_W    = 16,
   parameter logic [15:0] KEY_VAL  = 16'hA55A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             key_sel,
   input  logic [KEY_W-1:0] key_data,
   output logic             wr_ok,
   output logic             ready,
   output logic             key_open
);
   localparam int CNT_W = $clog2(BUSY_CYC + 1);

   logic [CNT_W-1:0] busy_cnt;

   initial begin
      assert (BUSY_CYC >= 1) else $error("BUSY_CYC must be at least 1");
      assert (KEY_W >= 1 && KEY_W <= 16) else $error("KEY_W out of range");
   end

   assign ready = (busy_cnt == '0);
   assign wr_ok = wr_req && !key_sel && ready && key_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_cnt <= '0;
      else if (wr_ok)
         busy_cnt <= CNT_W'(BUSY_CYC);
      else if (busy_cnt != '0)
         busy_cnt <= busy_cnt - 1'b1;
   end

   generate
      if (KEY_EN) begin : g_key
         logic key_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               key_q <= 1'b0;
            else if (wr_req && key_sel && key_data == KEY_VAL[KEY_W-1:0])
               key_q <= 1'b1;
            else if (wr_ok)
               key_q <= 1'b0;
         end
         assign key_open = key_q;

         a_r3_key_used_up: assert property (@(posedge clk) disable iff (!rst_n)
            wr_ok |=> !key_open);
      end else begin : g_nokey
         assign key_open = 1'b1;
      end
   endgenerate

   a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> !ready);
   a_r4_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !wr_ok);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   logic [PRE_W-1:0] cnt;
   logic             at_end;

   initial assert (PRE_W >= 1 && PRE_W <= 32) else $error("PRE_W out of range");

   assign at_end = (cnt >= limit);
   assign tick   = run && !restart && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || restart || at_end)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   a_r5_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || restart) |=> !tick || limit == '0);
endmodule

// File: rtl/rtc_alarm_det.sv
module rtc_alarm_det #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] secs,
   input  logic [W-1:0] alarm,
   input  logic         clr,
   output logic         flag
);
   logic match, match_q;

   assign match = en && (secs == alarm);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         flag    <= 1'b0;
      end else begin
         match_q <= match;
         if (match && !match_q)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
      end
   end

   a_r8_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(en && secs == alarm));
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
   parameter int          ADDR_W   = 8,
   parameter int          PRE_W    = 16,
   parameter logic [31:0] PRE_RST  = 32'd32767,
   parameter int          BUSY_CYC = 3,
   parameter bit          KEY_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o
);
   import rtc_pkg::*;

   localparam int DW = 32;

   initial assert (ADDR_W >= 6) else $error("ADDR_W too small for register map");

   logic              sel_ctrl, sel_secs, sel_alarm, sel_tlen, sel_scr, sel_key;
   logic              wr_ok, ready, key_open, tick, alm_flag, tick_flag;
   logic [DW-1:0]     secs, alarm, scratch;
   logic [PRE_W-1:0]  tlen;
   rtc_cfg_t          cfg;
   logic              w_ctrl, w_secs;

   assign sel_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
   assign sel_secs  = bus_addr == ADDR_W'(OFF_SECS);
   assign sel_alarm = bus_addr == ADDR_W'(OFF_ALARM);
   assign sel_tlen  = bus_addr == ADDR_W'(OFF_TLEN);
   assign sel_scr   = bus_addr == ADDR_W'(OFF_SCR);
   assign sel_key   = bus_addr == ADDR_W'(OFF_KEY);

   assign w_ctrl = wr_ok && sel_ctrl;
   assign w_secs = wr_ok && sel_secs;

   rtc_wr_gate #(.KEY_EN(KEY_EN), .BUSY_CYC(BUSY_CYC), .KEY_W(16),
                 .KEY_VAL(UNLOCK_CODE)) u_gate (
      .clk(clk), .rst_n(rst_n), .wr_req(bus_wr), .key_sel(sel_key),
      .key_data(bus_wdata[15:0]), .wr_ok(wr_ok), .ready(ready),
      .key_open(key_open));

   rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(cfg.run), .restart(w_secs),
      .limit(tlen), .tick(tick));

   rtc_alarm_det #(.W(DW)) u_alm (
      .clk(clk), .rst_n(rst_n), .en(cfg.alm_en), .secs(secs), .alarm(alarm),
      .clr(w_ctrl && !bus_wdata[B_ALMF]), .flag(alm_flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         secs      <= '0;
         alarm     <= '0;
         scratch   <= '0;
         tlen      <= PRE_W'(PRE_RST);
         cfg       <= '0;
         tick_flag <= 1'b0;
      end else begin
         if (w_secs)
            secs <= bus_wdata;
         else if (tick)
            secs <= secs + 32'd1;
         if (wr_ok && sel_alarm) alarm   <= bus_wdata;
         if (wr_ok && sel_scr)   scratch <= bus_wdata;
         if (wr_ok && sel_tlen)  tlen    <= bus_wdata[PRE_W-1:0];
         if (w_ctrl) begin
            cfg.tick_ie <= bus_wdata[B_TICKIE];
            cfg.alm_ie  <= bus_wdata[B_ALMIE];
            cfg.alm_en  <= bus_wdata[B_ALMEN];
            cfg.run     <= bus_wdata[B_RUN];
         end
         if (tick)
            tick_flag <= 1'b1;
         else if (w_ctrl && !bus_wdata[B_TICKF])
            tick_flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[B_RDY]    = ready;
         bus_rdata[B_TICKF]  = tick_flag;
         bus_rdata[B_TICKIE] = cfg.tick_ie;
         bus_rdata[B_ALMF]   = alm_flag;
         bus_rdata[B_ALMIE]  = cfg.alm_ie;
         bus_rdata[B_ALMEN]  = cfg.alm_en;
         bus_rdata[B_RUN]    = cfg.run;
      end else if (sel_secs)  bus_rdata = secs;
      else if (sel_alarm)     bus_rdata = alarm;
      else if (sel_tlen)      bus_rdata = DW'(tlen);
      else if (sel_scr)       bus_rdata = scratch;
      else if (sel_key)       bus_rdata[B_KEYOPEN] = key_open;
   end

   assign irq_o = (tick_flag && cfg.tick_ie) || (alm_flag && cfg.alm_ie);

   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !w_secs) |=> secs == $past(secs) + 32'd1);
   a_r6_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.run && !w_secs) |=> $stable(secs));
   a_r2_dropped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !wr_ok) |=> $stable(scratch) && $stable(alarm));
   a_r7_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> tick_flag);
endmodule

// File: tb/rtc_core_tb.sv
`timescale 1ns/100ps
module rtc_core_tb;
   localparam int PRE_RST = 9;
   localparam logic [7:0] A_CTRL = 8'h00, A_SECS = 8'h04, A_ALM = 8'h08,
                          A_TLEN = 8'h0C, A_SCR = 8'h34, A_KEY = 8'h3C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rtc_core #(.ADDR_W(8), .PRE_W(16), .PRE_RST(PRE_RST), .BUSY_CYC(3),
              .KEY_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.1;
      d = bus_rdata;
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      logic [31:0] c;
      rd(A_CTRL, c);
      while (!c[7]) begin
         @(negedge clk);
         rd(A_CTRL, c);
      end
      bus_write(A_KEY, 32'h0000A55A);
      bus_write(a, d);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h80);
      rd(A_SECS, v);  chk("R1 secs", v, 0);
      rd(A_ALM, v);   chk("R1 alarm", v, 0);
      rd(A_TLEN, v);  chk("R1 tlen", v, PRE_RST);
      rd(A_SCR, v);   chk("R1 scratch", v, 0);
      rd(A_KEY, v);   chk("R1 key", v, 0);
      chk("R1 irq", {31'b0, irq_o}, 0);

      // R2 locked writes dropped, key handling
      bus_write(A_SCR, 32'h1234);
      rd(A_SCR, v);   chk("R2 locked write", v, 0);
      bus_write(A_KEY, 32'h1111);
      rd(A_KEY, v);   chk("R2 wrong key", v, 0);
      bus_write(A_KEY, 32'hA55A);
      rd(A_KEY, v);   chk("R2 key open", v, 32'h8000_0000);

      // R3 / R4 accepted write consumes key, ready low 3 cycles
      bus_write(A_SCR, 32'hDEADBEEF);
      rd(A_SCR, v);   chk("R11 scratch write", v, 32'hDEADBEEF);
      rd(A_KEY, v);   chk("R3 key closed", v, 0);
      rd(A_CTRL, v);  chk("R4 ready low c1", v & 32'h80, 0);
      @(negedge clk); rd(A_CTRL, v); chk("R4 ready low c2", v & 32'h80, 0);
      @(negedge clk); rd(A_CTRL, v); chk("R4 ready low c3", v & 32'h80, 0);
      @(negedge clk); rd(A_CTRL, v); chk("R4 ready back", v & 32'h80, 32'h80);

      // R4 write while busy is dropped and keeps key
      bus_write(A_KEY, 32'hA55A);
      bus_write(A_SCR, 32'hCAFE0001);
      bus_write(A_KEY, 32'hA55A);
      bus_write(A_SCR, 32'h00000BAD);
      rd(A_SCR, v);   chk("R4 busy write dropped", v, 32'hCAFE0001);
      rd(A_KEY, v);   chk("R4 key kept", v, 32'h8000_0000);

      // R11 scratch sweep
      for (int i = 0; i < 8; i++) begin
         reg_wr(A_SCR, 32'h0101_0101 * (i + 1) ^ (32'h1 << (i * 4)));
         rd(A_SCR, v);
         chk("R11 scratch sweep", v, 32'h0101_0101 * (i + 1) ^ (32'h1 << (i * 4)));
      end

      // R5 / R10 prescaler sweep over tick lengths
      for (int n = 0; n < 6; n++) begin
         reg_wr(A_TLEN, n);
         reg_wr(A_CTRL, 32'h51);
         reg_wr(A_SECS, 1000);
         for (int k = 1; k <= 3; k++) begin
            repeat (n) @(negedge clk);
            rd(A_SECS, v); chk("R10 before step", v, 1000 + k - 1);
            @(negedge clk);
            rd(A_SECS, v); chk("R5 step", v, 1000 + k);
         end
      end

      // R6 hold while stopped
      reg_wr(A_CTRL, 32'h50);
      rd(A_SECS, s0);
      repeat (20) @(negedge clk);
      rd(A_SECS, v); chk("R6 hold", v, s0);

      // R6 wrap
      reg_wr(A_TLEN, 1);
      reg_wr(A_SECS, 32'hFFFF_FFFE);
      reg_wr(A_CTRL, 32'h51);
      repeat (2) @(negedge clk);
      rd(A_SECS, v); chk("R6 pre-wrap", v, 32'hFFFF_FFFF);
      repeat (2) @(negedge clk);
      rd(A_SECS, v); chk("R6 wrap", v, 0);

      // R7 tick flag write-0-to-clear
      reg_wr(A_CTRL, 32'h50);
      rd(A_CTRL, v); chk("R7 flag set", v & 32'h40, 32'h40);
      reg_wr(A_CTRL, 32'h50);
      rd(A_CTRL, v); chk("R7 write1 keeps", v & 32'h40, 32'h40);
      reg_wr(A_CTRL, 32'h10);
      rd(A_CTRL, v); chk("R7 write0 clears", v & 32'h50, 0);

      // R8 / R9 alarm through counting
      reg_wr(A_TLEN, 4);
      reg_wr(A_ALM, 2002);
      reg_wr(A_CTRL, 32'h54);
      reg_wr(A_SECS, 2000);
      reg_wr(A_CTRL, 32'h55);
      repeat (10) @(negedge clk);
      rd(A_SECS, v); chk("R5 reach alarm", v, 2002);
      rd(A_CTRL, v); chk("R8 not yet", v & 32'h10, 0);
      @(negedge clk);
      rd(A_CTRL, v); chk("R8 alarm set", v & 32'h10, 32'h10);
      chk("R9 irq masked", {31'b0, irq_o}, 0);
      reg_wr(A_CTRL, 32'h5D);
      chk("R9 alarm irq", {31'b0, irq_o}, 1);
      rd(A_CTRL, v); chk("R8 flag kept", v & 32'h10, 32'h10);
      reg_wr(A_CTRL, 32'h4D);
      rd(A_CTRL, v); chk("R8 alarm cleared", v & 32'h10, 0);
      chk("R9 irq off", {31'b0, irq_o}, 0);
      reg_wr(A_CTRL, 32'h6D);
      chk("R9 tick irq", {31'b0, irq_o}, 1);
      reg_wr(A_CTRL, 32'h6C);
      reg_wr(A_CTRL, 32'h2C);
      chk("R9 tick irq cleared", {31'b0, irq_o}, 0);

      // R8 alarm enable gating
      reg_wr(A_CTRL, 32'h50);
      reg_wr(A_ALM, 3000);
      reg_wr(A_SECS, 3000);
      repeat (3) @(negedge clk);
      rd(A_CTRL, v); chk("R8 disabled no set", v & 32'h10, 0);
      reg_wr(A_CTRL, 32'h54);
      @(negedge clk);
      rd(A_CTRL, v); chk("R8 set on enable", v & 32'h10, 32'h10);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule